// File: doc/BRIEF.md
# Pulsed Daisy-Chain Bus Arbiter and Cycle Sequencer

This block decides which of several slots on a shared bus may run the next transfer. It also sequences that transfer. At the host end, a generator sends a train of grant pulses into a chain of slot cells. Each cell either passes its grant input to its grant output or blocks it.

A slot with a pending request blocks the chain. It becomes the owner when it sees a rising edge on its own grant input. The owner then pulls a shared open-collector busy line low, and the generator emits no further rising edges while that line is low. The owner drives its address onto the bus and strobes a single open-collector handshake line low. It waits for the line to float high again and then releases busy. This release frees the bus and lets the grant pulses resume.

Open-collector lines are modelled as a wired-AND of active-low drive enables. Slaves take part only through their own drive enable on the handshake line. A slave answers by pulling the line low during the master's strobe and holding it until it is ready. If the line is already high in the first cycle after the strobe, no slave answered, and the cycle ends with a no-response result. Slot 0 is the host's position at the head of the chain and has the highest priority. Priority falls with each step down the chain.

Sequencer states:
- IDLE: waiting for a request.
- ARM: blocking the chain and waiting for a grant rise.
- ADDR: busy low, address setup for one cycle.
- STROBE: handshake driven low for a fixed count.
- WAIT: handshake released, waiting for the line to go high.
- DONE: busy released, result reported.

Sequencer transitions:
- IDLE→ARM on a request.
- ARM→ADDR on a grant rise.
- ADDR→STROBE after one cycle.
- STROBE→WAIT when the count ends.
- WAIT→DONE when the line is high.
- DONE→IDLE after one cycle.

Generator states:
- LOW: counting the gap.
- HIGH: counting the pulse.

Generator transitions:
- LOW→HIGH when the gap is over and busy is high.
- HIGH→LOW when the pulse width is reached.

Top module: `pulse_chain_arbiter`

## Requirements
- R1: After reset, the following hold: `grant_src_o` and all chain outputs are 0, `busy_n_o` and `hs_n_o` are 1, `bus_addr_o` is 0, and no `done_o` bit is set.
- R2: While the bus is idle, `grant_src_o` is high for PULSE_W cycles, and its rising edges are PERIOD cycles apart.
- R3: A slot that is not requesting or owning sets `gnt_chain_o[i]` to its grant input one cycle later. The grant input of slot 0 is `grant_src_o`, and the grant input of slot i is `gnt_chain_o[i-1]`.
- R4: A one-cycle pulse on `req_i[i]` arms slot i. The slot drives `busy_n_o` low after a rising edge reaches its grant input.
- R5: `grant_src_o` never rises while `busy_n_o` is low. Pulsing resumes within PERIOD cycles after busy returns high.
- R6: When several slots are armed before a grant rise, the slot with the lowest index wins. At most one slot drives busy at any time.
- R7: An owner keeps busy low until its cycle ends, even if a slot of higher priority requests meanwhile.
- R8: While busy is low, `bus_addr_o` carries the owner's address as latched at its request. While idle, it is 0.
- R9: The owner drives `hs_n_o` low for exactly STROBE_W cycles. When the line is seen high afterwards, the owner releases busy and pulses `done_o[i]` with `no_resp_o[i]` = 0 if a slave answered.
- R10: If `hs_n_o` is high in the first cycle after the strobe, `done_o[i]` pulses with `no_resp_o[i]` = 1.
- R11: If a slave holds the handshake line low past the strobe, busy stays low and no done is reported until the slave lets go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_SLOTS | One-cycle request pulse per slot |
| addr_i | input | N_SLOTS*AW | Request address per slot, slot i at bits [i*AW +: AW] |
| slv_hold_i | input | N_SLOTS | Slave drive enable on the handshake line (1 pulls it low) |
| grant_src_o | output | 1 | Grant pulse leaving the host-end generator |
| gnt_chain_o | output | N_SLOTS | Grant output of each slot cell |
| busy_n_o | output | 1 | Wired-AND busy line (low means owned) |
| hs_n_o | output | 1 | Wired-AND handshake line |
| bus_addr_o | output | AW | Address on the bus, driven by the owner |
| done_o | output | N_SLOTS | One-cycle end-of-cycle pulse per slot |
| no_resp_o | output | N_SLOTS | Valid with done: 1 if no slave answered |

## Verification
The assertions assume the following about the inputs:
- A request pulse arrives only at a slot whose sequencer is idle.
- A slave asserts its hold only while the handshake line is already low from a master strobe.
- A slave releases its hold within a bounded time.

The directed tasks respect these rules. They issue each request only after the previous cycle of that slot is reported done. The slave model raises its hold only on seeing the line low, and it always drops the hold after a fixed count. Priority tests arm requests just after a grant pulse has left the generator, so the next rising edge meets all armed slots.

// File: rtl/pulse_chain_pkg.sv
package pulse_chain_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ARM,
        SQ_ADDR,
        SQ_STROBE,
        SQ_WAIT,
        SQ_DONE
    } seq_state_t;

    typedef enum logic {
        GEN_LOW,
        GEN_HIGH
    } gen_state_t;

endpackage

// File: rtl/grant_pulse_gen.sv
module grant_pulse_gen
    import pulse_chain_pkg::*;
#(
    parameter int PERIOD  = 16,
    parameter int PULSE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_line_i,
    output logic grant_o
);
    localparam int CW     = $clog2(PERIOD + 1);
    localparam int GAP    = PERIOD - PULSE_W;
    localparam logic [CW-1:0] GAP_END   = CW'(GAP - 1);
    localparam logic [CW-1:0] PULSE_END = CW'(PULSE_W - 1);

    gen_state_t    state_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GEN_LOW;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                GEN_LOW: begin
                    if (cnt_q >= GAP_END && busy_line_i) begin
                        state_q <= GEN_HIGH;
                        cnt_q   <= '0;
                    end else if (cnt_q < GAP_END) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                GEN_HIGH: begin
                    if (cnt_q == PULSE_END) begin
                        state_q <= GEN_LOW;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= GEN_LOW;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        grant_o = (state_q == GEN_HIGH);
    end

    // R5
    no_rise_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_o) |-> $past(busy_line_i));

endmodule

// File: rtl/chain_cell.sv
module chain_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic gin_i,
    input  logic block_i,
    output logic gout_o,
    output logic grise_o
);
    logic gin_d_q;
    logic gout_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gin_d_q <= 1'b0;
            gout_q  <= 1'b0;
        end else begin
            gin_d_q <= gin_i;
            gout_q  <= block_i ? 1'b0 : gin_i;
        end
    end

    always_comb begin
        gout_o  = gout_q;
        grise_o = gin_i & ~gin_d_q;
    end

    // R3
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(block_i) |-> gout_o == $past(gin_i));

endmodule

// File: rtl/cycle_sequencer.sv
module cycle_sequencer
    import pulse_chain_pkg::*;
#(
    parameter int AW       = 8,
    parameter int STROBE_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW-1:0] addr_i,
    input  logic          grise_i,
    input  logic          hs_line_i,
    output logic          block_o,
    output logic          busy_drv_o,
    output logic          hs_drv_o,
    output logic [AW-1:0] addr_drv_o,
    output logic          done_o,
    output logic          no_resp_o
);
    localparam int SW = $clog2(STROBE_W + 1);
    localparam logic [SW-1:0] STROBE_END = SW'(STROBE_W - 1);

    seq_state_t    state_q;
    logic [SW-1:0] cnt_q;
    logic [AW-1:0] addr_q;
    logic          first_q;
    logic          nores_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            first_q <= 1'b0;
            nores_q <= 1'b0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (req_i) begin
                        addr_q  <= addr_i;
                        state_q <= SQ_ARM;
                    end
                end
                SQ_ARM: begin
                    if (grise_i) begin
                        state_q <= SQ_ADDR;
                    end
                end
                SQ_ADDR: begin
                    cnt_q   <= '0;
                    state_q <= SQ_STROBE;
                end
                SQ_STROBE: begin
                    if (cnt_q == STROBE_END) begin
                        first_q <= 1'b1;
                        state_q <= SQ_WAIT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_WAIT: begin
                    if (hs_line_i) begin
                        nores_q <= first_q;
                        state_q <= SQ_DONE;
                    end
                    first_q <= 1'b0;
                end
                SQ_DONE: begin
                    state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        block_o    = 1'b0;
        busy_drv_o = 1'b0;
        hs_drv_o   = 1'b0;
        done_o     = 1'b0;
        no_resp_o  = 1'b0;
        unique case (state_q)
            SQ_IDLE:   ;
            SQ_ARM:    block_o = 1'b1;
            SQ_ADDR:   begin block_o = 1'b1; busy_drv_o = 1'b1; end
            SQ_STROBE: begin block_o = 1'b1; busy_drv_o = 1'b1; hs_drv_o = 1'b1; end
            SQ_WAIT:   begin block_o = 1'b1; busy_drv_o = 1'b1; end
            SQ_DONE:   begin done_o = 1'b1; no_resp_o = nores_q; end
            default:   ;
        endcase
        addr_drv_o = busy_drv_o ? addr_q : '0;
    end

    // R7
    hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_drv_o) |-> state_q == SQ_DONE);

    // R9
    strobe_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_drv_o |-> busy_drv_o);

    // R10
    report_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_drv_o));

endmodule

// File: rtl/pulse_chain_arbiter.sv
module pulse_chain_arbiter
    import pulse_chain_pkg::*;
#(
    parameter int N_SLOTS  = 4,
    parameter int AW       = 8,
    parameter int PERIOD   = 16,
    parameter int PULSE_W  = 4,
    parameter int STROBE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_SLOTS-1:0]    req_i,
    input  logic [N_SLOTS*AW-1:0] addr_i,
    input  logic [N_SLOTS-1:0]    slv_hold_i,
    output logic                  grant_src_o,
    output logic [N_SLOTS-1:0]    gnt_chain_o,
    output logic                  busy_n_o,
    output logic                  hs_n_o,
    output logic [AW-1:0]         bus_addr_o,
    output logic [N_SLOTS-1:0]    done_o,
    output logic [N_SLOTS-1:0]    no_resp_o
);
    logic [N_SLOTS-1:0]  gin;
    logic [N_SLOTS-1:0]  grise;
    logic [N_SLOTS-1:0]  block;
    logic [N_SLOTS-1:0]  busy_drv;
    logic [N_SLOTS-1:0]  hs_drv;
    logic [AW-1:0]       addr_drv [N_SLOTS];
    logic                busy_line;
    logic                hs_line;

    always_comb begin
        busy_line = ~(|busy_drv);
        hs_line   = ~((|hs_drv) | (|slv_hold_i));
    end

    grant_pulse_gen #(.PERIOD(PERIOD), .PULSE_W(PULSE_W)) u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_line_i (busy_line),
        .grant_o     (grant_src_o)
    );

    genvar i;
    generate
        for (i = 0; i < N_SLOTS; i++) begin : g_slot
            if (i == 0) begin : g_head
                assign gin[i] = grant_src_o;
            end else begin : g_tail
                assign gin[i] = gnt_chain_o[i-1];
            end

            chain_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .gin_i   (gin[i]),
                .block_i (block[i]),
                .gout_o  (gnt_chain_o[i]),
                .grise_o (grise[i])
            );

            cycle_sequencer #(.AW(AW), .STROBE_W(STROBE_W)) u_seq (
                .clk        (clk),
                .rst_n      (rst_n),
                .req_i      (req_i[i]),
                .addr_i     (addr_i[i*AW +: AW]),
                .grise_i    (grise[i]),
                .hs_line_i  (hs_line),
                .block_o    (block[i]),
                .busy_drv_o (busy_drv[i]),
                .hs_drv_o   (hs_drv[i]),
                .addr_drv_o (addr_drv[i]),
                .done_o     (done_o[i]),
                .no_resp_o  (no_resp_o[i])
            );
        end
    endgenerate

    always_comb begin
        bus_addr_o = '0;
        for (int k = 0; k < N_SLOTS; k++) begin
            bus_addr_o = bus_addr_o | addr_drv[k];
        end
        busy_n_o = busy_line;
        hs_n_o   = hs_line;
    end

    // R6
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_drv));

    // R8
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_n_o |-> bus_addr_o == '0);

endmodule

// File: tb/pulse_chain_arbiter_test.sv
module pulse_chain_arbiter_test;
    localparam int CLK_P    = 10;
    localparam int N        = 4;
    localparam int AW       = 8;
    localparam int PERIOD   = 16;
    localparam int PULSE_W  = 4;
    localparam int STROBE_W = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req = '0;
    logic [N*AW-1:0] addr = '0;
    logic [N-1:0]    slv_hold = '0;
    logic            grant_src;
    logic [N-1:0]    gnt_chain;
    logic            busy_n, hs_n;
    logic [AW-1:0]   bus_addr;
    logic [N-1:0]    done, no_resp;

    int checks = 0;
    int errors = 0;
    int rise_busy_viol = 0;
    int pass_mism = 0;
    bit pass_mon = 1'b0;
    logic prev_src = 1'b0, prev_busy = 1'b1;
    logic [N-1:0] prev_chain = '0;

    always #(CLK_P/2) clk = ~clk;

    pulse_chain_arbiter #(.N_SLOTS(N), .AW(AW), .PERIOD(PERIOD),
                          .PULSE_W(PULSE_W), .STROBE_W(STROBE_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr),
        .slv_hold_i(slv_hold), .grant_src_o(grant_src), .gnt_chain_o(gnt_chain),
        .busy_n_o(busy_n), .hs_n_o(hs_n), .bus_addr_o(bus_addr),
        .done_o(done), .no_resp_o(no_resp));

    always @(negedge clk) begin
        if (rst_n) begin
            if (grant_src && !prev_src && !prev_busy) rise_busy_viol++;
            if (pass_mon) begin
                if (gnt_chain[0] !== prev_src) pass_mism++;
                for (int k = 1; k < N; k++)
                    if (gnt_chain[k] !== prev_chain[k-1]) pass_mism++;
            end
        end
        prev_src   = grant_src;
        prev_busy  = busy_n;
        prev_chain = gnt_chain;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic request(input int slot, input logic [AW-1:0] a);
        addr[slot*AW +: AW] = a;
        req[slot] = 1'b1;
        @(negedge clk);
        req[slot] = 1'b0;
    endtask

    task automatic wait_src_rise(output int cyc);
        cyc = 0;
        while (!(grant_src && !prev_src) && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic wait_done(output int idx, output bit nr);
        idx = -1; nr = 1'b0;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (|done) begin
                for (int k = 0; k < N; k++)
                    if (done[k]) begin idx = k; nr = no_resp[k]; end
                return;
            end
        end
    endtask

    task automatic slave_answer(input int s, input int hold);
        for (int c = 0; c < 300 && hs_n; c++) @(negedge clk);
        slv_hold[s] = 1'b1;
        repeat (hold) @(negedge clk);
        slv_hold[s] = 1'b0;
    endtask

    task automatic t_reset();
        check(grant_src == 1'b0 && gnt_chain == '0, "R1 grant after reset", int'(gnt_chain), 0);
        check(busy_n && hs_n, "R1 lines after reset", int'({busy_n, hs_n}), 3);
        check(bus_addr == '0 && done == '0, "R1 addr/done after reset", int'(bus_addr), 0);
    endtask

    task automatic t_pulses();
        int c, w, p;
        wait_src_rise(c);
        w = 0;
        while (grant_src) begin @(negedge clk); w++; end
        check(w == PULSE_W, "R2 pulse width", w, PULSE_W);
        p = w;
        while (!(grant_src && !prev_src)) begin @(negedge clk); p++; end
        check(p == PERIOD, "R2 pulse period", p, PERIOD);
    endtask

    task automatic t_pass();
        pass_mism = 0;
        pass_mon = 1'b1;
        repeat (3 * PERIOD) @(negedge clk);
        pass_mon = 1'b0;
        check(pass_mism == 0, "R3 idle chain delay", pass_mism, 0);
    endtask

    task automatic t_answered();
        int c, idx; bit nr;
        fork slave_answer(1, 8); join_none
        request(2, 8'hA5);
        c = 0;
        while (busy_n && c < 100) begin @(negedge clk); c++; end
        check(!busy_n, "R4 owner pulls busy", int'(busy_n), 0);
        check(bus_addr == 8'hA5, "R8 owner address on bus", int'(bus_addr), 'hA5);
        while (hs_n && c < 200) begin @(negedge clk); c++; end
        repeat (STROBE_W + 2) @(negedge clk);
        check(!busy_n && done == '0, "R11 busy held while slave holds", int'(busy_n), 0);
        wait_done(idx, nr);
        check(idx == 2 && nr == 1'b0, "R9 done with response", idx, 2);
        check(busy_n && bus_addr == '0, "R8 bus idle after cycle", int'(bus_addr), 0);
        wait_src_rise(c);
        check(c <= PERIOD + 2, "R5 pulsing resumes", c, PERIOD);
    endtask

    task automatic t_noresp();
        int c, w, idx; bit nr;
        request(3, 8'h3C);
        c = 0;
        while (hs_n && c < 200) begin @(negedge clk); c++; end
        w = 0;
        while (!hs_n && w < 50) begin @(negedge clk); w++; end
        check(w == STROBE_W, "R9 strobe width", w, STROBE_W);
        wait_done(idx, nr);
        check(idx == 3 && nr == 1'b1, "R10 no-response reported", int'(nr), 1);
    endtask

    task automatic t_priority();
        int idx1, idx2; bit nr;
        while (!grant_src) @(negedge clk);
        while (grant_src) @(negedge clk);
        addr[1*AW +: AW] = 8'h11;
        addr[3*AW +: AW] = 8'h33;
        req[1] = 1'b1; req[3] = 1'b1;
        @(negedge clk);
        req = '0;
        wait_done(idx1, nr);
        wait_done(idx2, nr);
        check(idx1 == 1, "R6 nearer slot first", idx1, 1);
        check(idx2 == 3, "R6 farther slot second", idx2, 3);
    endtask

    task automatic t_no_preempt();
        int c, idx1, idx2; bit nr;
        fork slave_answer(0, 30); join_none
        request(2, 8'h5A);
        c = 0;
        while (busy_n && c < 100) begin @(negedge clk); c++; end
        request(0, 8'h77);
        repeat (10) @(negedge clk);
        check(!busy_n && bus_addr == 8'h5A, "R7 owner keeps bus", int'(bus_addr), 'h5A);
        check(done == '0, "R7 no early done", int'(done), 0);
        wait_done(idx1, nr);
        wait_done(idx2, nr);
        check(idx1 == 2, "R7 owner finishes first", idx1, 2);
        check(idx2 == 0, "R6 host slot served next", idx2, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_pulses();
        t_pass();
        t_answered();
        t_noresp();
        t_priority();
        t_no_preempt();
        repeat (5) @(negedge clk);
        check(rise_busy_viol == 0, "R5 no rise while busy", rise_busy_viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule